// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Core

This core models the clocked side of a synchronous burst static RAM. On each rising clock edge it reads a primary chip enable, two secondary enables, a processor-side and a controller-side address strobe, a burst-advance input and a write qualifier. From these it decodes one of four cycle types: deselect, begin burst, continue burst or suspend burst. A burst address register either loads the external address, steps the two low bits in linear order with wrap-around inside a four-word block, or holds.

Reads are pipelined: the address is registered on the clock edge of the cycle, and the array output register loads one edge later. Writes commit to the on-chip array on the edge of the write cycle. An asynchronous output enable gates the read drivers. A host that ties the processor strobe inactive and pulses the controller strobe gets plain single accesses. Holding the advance input low as well turns the following idle-strobe cycles into a linear burst.

Top module: `sync_burst_sram`

## Requirements
- R1: The composite enable is true only when `ce2_i`=1 and `ce3_n_i`=0. With `ce_n_i`=0 and the composite enable false, a cycle where either strobe is low is a deselect: nothing is written, and the drivers are off after the next two edges.
- R2: With `ce_n_i`=1 and `ads_ctrl_n_i`=0, the cycle is a deselect whatever `ads_proc_n_i` is. Nothing is written and no read is started.
- R3: With `ce_n_i`=0, the composite enable true and `ads_proc_n_i`=0, a burst starts at `addr_i` as a read, whatever `wr_i` and `ads_ctrl_n_i` are.
- R4: With `ce_n_i`=0, the composite enable true, `ads_proc_n_i`=1 and `ads_ctrl_n_i`=0, a burst starts at `addr_i`. It writes `wdata_i` when `wr_i`=1 and reads when `wr_i`=0.
- R5: With `ads_ctrl_n_i`=1, `adv_n_i`=0, and either `ads_proc_n_i`=1 or `ce_n_i`=1, the cycle continues the burst. Address bits [1:0] increment modulo 4 and the upper bits stay fixed. `wr_i` selects write or read.
- R6: The same strobe condition with `adv_n_i`=1 suspends the burst at the current address. `wr_i` still selects write or read.
- R7: Data of a read cycle at edge N shows on `rdata_o`, with `rdata_oe_o`=1, after edge N+1. A write cycle at edge N stores into the array at edge N.
- R8: `oe_n_i`=1 forces `rdata_oe_o` low at once, with no clock. `oe_n_i`=0 lets the drivers turn on only for a read result. When `rdata_oe_o`=0, `rdata_o` reads zero.
- R9: After reset or a deselect, a continue or suspend cycle acts as a deselect until a new burst has begun.
- R10: After reset, `rdata_oe_o`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_n_i | input | 1 | Primary chip enable, active low |
| ce2_i | input | 1 | Secondary enable, active high |
| ce3_n_i | input | 1 | Secondary enable, active low |
| ads_proc_n_i | input | 1 | Processor-side address strobe, active low |
| ads_ctrl_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| wr_i | input | 1 | Write qualifier, 1 = write |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| addr_i | input | AW | External address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, zero while not driven |
| rdata_oe_o | output | 1 | Read data driver enable |

## Verification
Assertions check the following on every cycle:
- the strobe priority: a processor-strobe start never writes, and a controller strobe with the chip deselected never starts an access;
- the step and hold of the burst address, including that upper bits stay fixed;
- the loss of the burst after a deselect;
- the immediate output-enable gate.

Only the bench's scenarios can show some behaviours:
- that the right array word appears exactly one edge after the address is registered;
- that the burst wraps inside its four-word block;
- that writes done by continue and suspend cycles land on the addresses that later reads return.

To show these, the bench runs a near-exhaustive sweep of all 128 control patterns against an arithmetic model.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_BEGIN = 2'd1,
    CYC_NEXT  = 2'd2,
    CYC_HOLD  = 2'd3
  } cyc_kind_e;

  typedef struct packed {
    cyc_kind_e kind;
    logic      wr;
  } cyc_t;

endpackage

// File: rtl/sbsram_cycle_decode.sv
module sbsram_cycle_decode
  import sbsram_pkg::*;
(
  input  logic ce_n_i,
  input  logic ce2_i,
  input  logic ce3_n_i,
  input  logic ads_proc_n_i,
  input  logic ads_ctrl_n_i,
  input  logic adv_n_i,
  input  logic wr_i,
  input  logic active_i,
  output cyc_t cyc_o
);

  logic en_all;
  assign en_all = ce2_i & ~ce3_n_i;

  always_comb begin
    cyc_o.kind = CYC_IDLE;
    cyc_o.wr   = 1'b0;
    if (ce_n_i) begin
      if (ads_ctrl_n_i && active_i) begin
        cyc_o.kind = adv_n_i ? CYC_HOLD : CYC_NEXT;
        cyc_o.wr   = wr_i;
      end
    end else if (!ads_proc_n_i) begin
      // processor strobe wins and always reads
      if (en_all) cyc_o.kind = CYC_BEGIN;
    end else if (!ads_ctrl_n_i) begin
      if (en_all) begin
        cyc_o.kind = CYC_BEGIN;
        cyc_o.wr   = wr_i;
      end
    end else if (active_i) begin
      cyc_o.kind = adv_n_i ? CYC_HOLD : CYC_NEXT;
      cyc_o.wr   = wr_i;
    end
  end

endmodule

// File: rtl/sbsram_burst_addr.sv
module sbsram_burst_addr
  import sbsram_pkg::*;
#(
  parameter int AW        = 6,
  parameter int BURST_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_t          cyc_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr_o,
  output logic [AW-1:0] addr_q_o,
  output logic          active_o
);

  localparam int LB = $clog2(BURST_LEN);
  localparam logic [LB-1:0] STEP = LB'(1);

  logic [AW-1:0] addr_q;
  logic          active_q;

  always_comb begin
    unique case (cyc_i.kind)
      CYC_BEGIN: eff_addr_o = addr_i;
      CYC_NEXT:  eff_addr_o = {addr_q[AW-1:LB], addr_q[LB-1:0] + STEP};
      default:   eff_addr_o = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      active_q <= 1'b0;
    end else begin
      addr_q <= eff_addr_o;
      if (cyc_i.kind == CYC_BEGIN)     active_q <= 1'b1;
      else if (cyc_i.kind == CYC_IDLE) active_q <= 1'b0;
    end
  end

  assign addr_q_o = addr_q;
  assign active_o = active_q;

  assert_next_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i.kind == CYC_NEXT) |=>
      ((addr_q[LB-1:0] == $past(addr_q[LB-1:0]) + STEP) &&
       (addr_q[AW-1:LB] == $past(addr_q[AW-1:LB]))));

  assert_hold_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i.kind == CYC_HOLD) |=> $stable(addr_q));

  assert_idle_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i.kind == CYC_IDLE) |=> !active_q);

endmodule

// File: rtl/sbsram_mem_array.sv
module sbsram_mem_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] dout_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // registered read port: old contents on a same-edge write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (re_i) dout_q <= mem_q[raddr_i];
  end

  assign rdata_o = dout_q;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int BURST_LEN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          ads_proc_n_i,
  input  logic          ads_ctrl_n_i,
  input  logic          adv_n_i,
  input  logic          wr_i,
  input  logic          oe_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdata_oe_o
);

  cyc_t          cyc;
  logic          active;
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] addr_q;
  logic          mem_we;
  logic          rd_pend_q;
  logic          drive_q;
  logic [DW-1:0] dout;

  sbsram_cycle_decode i_decode (
    .ce_n_i      (ce_n_i),
    .ce2_i       (ce2_i),
    .ce3_n_i     (ce3_n_i),
    .ads_proc_n_i(ads_proc_n_i),
    .ads_ctrl_n_i(ads_ctrl_n_i),
    .adv_n_i     (adv_n_i),
    .wr_i        (wr_i),
    .active_i    (active),
    .cyc_o       (cyc)
  );

  sbsram_burst_addr #(
    .AW       (AW),
    .BURST_LEN(BURST_LEN)
  ) i_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cyc_i     (cyc),
    .addr_i    (addr_i),
    .eff_addr_o(eff_addr),
    .addr_q_o  (addr_q),
    .active_o  (active)
  );

  assign mem_we = (cyc.kind != CYC_IDLE) && cyc.wr;

  sbsram_mem_array #(
    .AW(AW),
    .DW(DW)
  ) i_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .waddr_i(eff_addr),
    .wdata_i(wdata_i),
    .re_i   (rd_pend_q),
    .raddr_i(addr_q),
    .rdata_o(dout)
  );

  // stage 1: read decoded; stage 2: array word registered and driven
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      drive_q   <= 1'b0;
    end else begin
      rd_pend_q <= (cyc.kind != CYC_IDLE) && !cyc.wr;
      drive_q   <= rd_pend_q;
    end
  end

  assign rdata_oe_o = drive_q & ~oe_n_i;
  assign rdata_o    = rdata_oe_o ? dout : '0;

  assert_desel_hiz_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !(ce2_i && !ce3_n_i) && !(ads_proc_n_i && ads_ctrl_n_i))
      |=> (!rd_pend_q ##1 !drive_q));

  assert_ctrl_desel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_i && !ads_ctrl_n_i) |-> (!mem_we ##1 !rd_pend_q));

  assert_proc_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && ce2_i && !ce3_n_i && !ads_proc_n_i) |-> (!mem_we ##1 rd_pend_q));

  assert_oe_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !rdata_oe_o);

  assert_no_burst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && ads_ctrl_n_i && (ads_proc_n_i || ce_n_i)) |-> (!mem_we ##1 !rd_pend_q));

endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, wr = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_areg = '0;
  bit            m_act = 0;
  bit            m_pend = 0;
  bit            m_drive = 0;
  logic [DW-1:0] m_dout = '0;
  int            m_pend_tag = 0;
  int            m_drive_tag = 0;
  logic [15:0]   lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.AW(AW), .DW(DW), .BURST_LEN(4)) i_sync_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
    .ads_proc_n_i(adsp_n), .ads_ctrl_n_i(adsc_n), .adv_n_i(adv_n), .wr_i(wr),
    .oe_n_i(oe_n), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  function automatic string tag_name(int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      9: return "R9";
      default: return "R7";
    endcase
  endfunction

  function automatic logic [DW-1:0] pattern(int a);
    return DW'((a * 37 + 11) ^ (a >> 2));
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // one clock: advance the model by the requirements, then compare outputs
  task automatic tick();
    bit en, rd, wrc;
    int t;
    logic [AW-1:0] eff;
    @(posedge clk);
    m_drive = m_pend;
    m_drive_tag = m_pend_tag;
    if (m_pend) m_dout = m_mem[m_areg];
    en = ce2 && !ce3_n;
    eff = m_areg; rd = 0; wrc = 0;
    if (!ce_n && !en && (!adsp_n || !adsc_n)) t = 1;
    else if (ce_n && !adsc_n) t = 2;
    else if (!ce_n && en && !adsp_n) t = 3;
    else if (!ce_n && en && !adsc_n) t = 4;
    else if (!m_act) t = 9;
    else if (!adv_n) t = 5;
    else t = 6;
    case (t)
      3: begin eff = addr; rd = 1; end
      4: begin eff = addr; rd = !wr; wrc = wr; end
      5: begin eff = {m_areg[AW-1:2], m_areg[1:0] + 2'd1}; rd = !wr; wrc = wr; end
      6: begin rd = !wr; wrc = wr; end
      default: ;
    endcase
    if (wrc) m_mem[eff] = wdata;
    m_areg = eff;
    m_act = (t == 3 || t == 4) ? 1 : (t == 5 || t == 6) ? m_act : 0;
    m_pend = rd;
    m_pend_tag = t;
    #2;
    check(tag_name(m_drive_tag), {7'd0, rdata_oe}, {7'd0, m_drive && !oe_n});
    if (m_drive && !oe_n) check("R7", rdata, m_dout);
    else check("R8", rdata, '0);
  endtask

  task automatic set_ctl(bit c1, bit c2, bit c3n, bit pn, bit cn, bit vn, bit w);
    ce_n = c1; ce2 = c2; ce3_n = c3n; adsp_n = pn; adsc_n = cn; adv_n = vn; wr = w;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    #(CLK_PERIOD * 3 + 2);
    // R10: reset state
    check("R10", {7'd0, rdata_oe}, 8'd0);
    check("R10", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // preload every word through the controller strobe (R4 write)
    for (int a = 0; a < DEPTH; a++) begin
      set_ctl(0, 1, 0, 1, 0, 1, 1);
      addr = AW'(a); wdata = pattern(a);
      tick();
    end

    // R4 read begin at low bits 2, then R5 continues: wrap 2,3,0,1
    set_ctl(0, 1, 0, 1, 0, 1, 0); addr = 6'h1E; tick();
    set_ctl(1, 0, 1, 1, 1, 0, 0); tick();
    check("R7", rdata, pattern(6'h1E));
    tick();
    check("R5", rdata, pattern(6'h1F));
    tick();
    check("R5", rdata, pattern(6'h1C));
    // R6 suspend keeps address 1D
    set_ctl(1, 0, 1, 1, 1, 1, 0); tick();
    check("R5", rdata, pattern(6'h1D));
    tick();
    check("R6", rdata, pattern(6'h1D));
    // R8: output enable acts without a clock
    oe_n = 1'b1; #1;
    check("R8", {7'd0, rdata_oe}, 8'd0);
    oe_n = 1'b0; #1;
    check("R8", {7'd0, rdata_oe}, 8'd1);

    // R3: processor strobe reads even with wr high
    set_ctl(0, 1, 0, 0, 0, 1, 1); addr = 6'h05; wdata = 8'h00; tick();
    set_ctl(1, 1, 0, 1, 1, 1, 0); tick(); tick();
    check("R3", rdata, pattern(5));
    // R2 deselect, then R9 continue is ignored
    set_ctl(1, 1, 0, 0, 0, 1, 1); tick();
    set_ctl(1, 1, 0, 1, 1, 0, 1); wdata = 8'hEE; tick(); tick(); tick();
    check("R9", {7'd0, rdata_oe}, 8'd0);
    set_ctl(0, 1, 0, 0, 1, 1, 0); addr = 6'h06; tick(); tick(); tick();
    check("R9", rdata, m_mem[6]);

    // near-exhaustive sweep of all control patterns
    for (int pass = 0; pass < 8; pass++) begin
      for (int c = 0; c < 128; c++) begin
        int sel;
        step_lfsr();
        sel = (pass == 0) ? c : int'(lfsr[6:0]);
        set_ctl(sel[6], sel[5], sel[4], sel[3], sel[2], sel[1], sel[0]);
        if (pass > 1 && lfsr[9:8] != 2'b00) adsc_n = 1'b1;
        if (pass > 1 && lfsr[11:10] != 2'b00) adsp_n = 1'b1;
        addr = lfsr[15:10];
        wdata = lfsr[7:0] ^ lfsr[15:8];
        oe_n = (pass == 5) ? lfsr[12] : 1'b0;
        tick();
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule